// File: doc/BRIEF.md
# Per-Channel Digital Milliwatt Inserter

This block sits in a T1 receive path on its way to the backplane. Bytes arrive one at a time. Each byte comes with a valid strobe and the number of the timeslot it belongs to, from 1 to 24. Each timeslot has its own enable bit. When that bit is set, the byte is dropped and the next byte of a fixed eight-byte sequence takes its place. That sequence encodes a 1 kHz test tone. When the bit is clear, the byte passes through unchanged. Every output is registered, so data, valid and channel number all leave one clock after they enter.

The position in the tone sequence is shared by all enabled channels. It moves forward once per frame, on the byte for timeslot 24. As a result, each enabled channel walks through the tone at the 8 kHz frame rate.

A host loads the 24 enable bits through three 8-bit registers. A write lands in a staging copy first. That copy goes live only at the next frame boundary, so a frame never mixes old and new settings.

Top module: `dmw_inserter`

## Requirements
- R1: After reset, out_vld, out_chan and out_data are all zero, every channel is disabled, and the tone position is 0.
- R2: out_vld is in_vld delayed by one clock. When in_vld is high, out_chan in the next cycle equals the in_chan that came with the byte.
- R3: reg_sel 0 loads channels 1 to 8, reg_sel 1 loads channels 9 to 16, and reg_sel 2 loads channels 17 to 24. Bit 0 of reg_wdata is the lowest channel of the group. A write with reg_sel 3 changes nothing.
- R4: A valid byte on an enabled channel comes out as the current tone byte. A valid byte on a disabled channel comes out unchanged.
- R5: The tone sequence at positions 0 to 7 is 1E, 0B, 0B, 1E, 9E, 8B, 8B, 9E (hex). Every enabled channel in one frame receives the byte at the same position.
- R6: The tone position advances by one on each valid byte whose channel is 24, and it wraps from 7 to 0. The channel-24 byte itself still uses the old position.
- R7: Written enables become active for the first byte after the next valid channel-24 byte. A write made in the same cycle as a channel-24 byte waits for the boundary after that one.
- R8: A valid byte with channel 0 or 25 to 31 passes through unchanged. It neither advances the tone position nor activates staged enables.
- R9: Cycles with in_vld low produce out_vld low. They neither advance the tone position nor activate staged enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input byte valid |
| in_chan | input | 5 | Timeslot number of the input byte, 1 to 24 |
| in_data | input | 8 | Input byte |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Enable register select |
| reg_wdata | input | 8 | Enable register write data |
| out_vld | output | 1 | Output byte valid |
| out_chan | output | 5 | Timeslot number of the output byte |
| out_data | output | 8 | Output byte |

## Verification
A single-bit enable is walked across all 24 timeslots. A design that mapped a register bit to the wrong channel would insert tone into the wrong slot. An all-enabled map runs for more than eight frames. An index that advanced per byte, or that failed to wrap, would break the 1E/0B/0B/1E/9E/8B/8B/9E order.

Several cases target the frame-boundary rule:
- Writes made mid-frame.
- A write made on the very channel-24 cycle.
- Out-of-range channel numbers.
- Idle gaps between bytes.

A design that applied writes at once, or that treated stray bytes as boundaries, would switch channels or move the tone position early.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  localparam int TONE_LEN = 8;
  localparam int IDX_W    = $clog2(TONE_LEN);

  // one period of the 1 kHz tone in mu-law bytes
  function automatic logic [7:0] tone_byte(input logic [IDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h1E;
      3'd1: b = 8'h0B;
      3'd2: b = 8'h0B;
      3'd3: b = 8'h1E;
      3'd4: b = 8'h9E;
      3'd5: b = 8'h8B;
      3'd6: b = 8'h8B;
      default: b = 8'h9E;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/dmw_enable_regs.sv
module dmw_enable_regs #(
  parameter int NUM_CH = 24,
  parameter int REG_W  = 8,
  parameter int CH_W   = 5,
  localparam int NUM_REGS = (NUM_CH + REG_W - 1) / REG_W,
  localparam int SEL_W    = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              commit,
  input  logic              in_vld,
  input  logic [CH_W-1:0]   in_chan,
  output logic [NUM_CH-1:0] active_map,
  output logic              ch_hit
);
  logic [NUM_REGS*REG_W-1:0] staged;

  // one staging byte per host register
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        staged[g*REG_W +: REG_W] <= '0;
      else if (reg_wr && reg_sel == SEL_W'(g))
        staged[g*REG_W +: REG_W] <= reg_wdata;
    end
  end

  // live copy switches only at a frame boundary (uses pre-write staging)
  always_ff @(posedge clk) begin
    if (!rst_n)
      active_map <= '0;
    else if (commit)
      active_map <= staged[NUM_CH-1:0];
  end

  always_comb begin
    ch_hit = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (in_vld && in_chan == CH_W'(c + 1))
        ch_hit = active_map[c];
  end
endmodule

// File: rtl/dmw_phase_ctr.sv
module dmw_phase_ctr #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] idx
);
  // natural wrap of the counter width gives 7 -> 0
  always_ff @(posedge clk) begin
    if (!rst_n)
      idx <= '0;
    else if (advance)
      idx <= idx + 1'b1;
  end
endmodule

// File: rtl/dmw_inserter.sv
module dmw_inserter #(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5,
  parameter int DATA_W = 8,
  parameter int REG_W  = 8,
  localparam int NUM_REGS = (NUM_CH + REG_W - 1) / REG_W,
  localparam int SEL_W    = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [DATA_W-1:0] in_data,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              out_vld,
  output logic [CH_W-1:0]   out_chan,
  output logic [DATA_W-1:0] out_data
);
  import dmw_pkg::*;

  // named internal events for the checker
  logic                 frame_end;
  logic                 ch_hit;
  logic [NUM_CH-1:0]    active_map;
  logic [IDX_W-1:0]     idx;
  logic [DATA_W-1:0]    next_data;

  assign frame_end = in_vld && (in_chan == CH_W'(NUM_CH));

  dmw_enable_regs #(.NUM_CH(NUM_CH), .REG_W(REG_W), .CH_W(CH_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .commit     (frame_end),
    .in_vld     (in_vld),
    .in_chan    (in_chan),
    .active_map (active_map),
    .ch_hit     (ch_hit)
  );

  dmw_phase_ctr #(.IDX_W(IDX_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (frame_end),
    .idx     (idx)
  );

  assign next_data = ch_hit ? DATA_W'(tone_byte(idx)) : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_chan <= '0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_chan <= in_chan;
        out_data <= next_data;
      end
    end
  end
endmodule

// File: rtl/dmw_inserter_chk.sv
module dmw_inserter_chk #(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [CH_W-1:0]   in_chan,
  input logic [DATA_W-1:0] in_data,
  input logic              out_vld,
  input logic [CH_W-1:0]   out_chan,
  input logic [DATA_W-1:0] out_data,
  input logic              frame_end,
  input logic              ch_hit,
  input logic [NUM_CH-1:0] active_map,
  input logic [IDX_W-1:0]  idx
);
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  a_r2_chan_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_chan == $past(in_chan));
  a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !ch_hit) |=> out_data == $past(in_data));
  a_r5_tone_out: assert property (@(posedge clk) disable iff (!rst_n)
    ch_hit |=> out_data == DATA_W'(dmw_pkg::tone_byte($past(idx))));
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> idx == $past(idx) + 1'b1);
  a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(idx));
  a_r7_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(active_map));
endmodule

bind dmw_inserter dmw_inserter_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .IDX_W(dmw_pkg::IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_chan(in_chan),
  .in_data(in_data), .out_vld(out_vld), .out_chan(out_chan),
  .out_data(out_data), .frame_end(frame_end), .ch_hit(ch_hit),
  .active_map(active_map), .idx(idx)
);

// File: tb/test_dmw_inserter.sv
module test_dmw_inserter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic [4:0] in_chan = '0;
  logic [7:0] in_data = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic       out_vld;
  logic [4:0] out_chan;
  logic [7:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench model
  logic [23:0] m_stage  = '0;
  logic [23:0] m_active = '0;
  int          m_idx    = 0;

  always #4 clk = ~clk; // 125 MHz

  dmw_inserter i_dmw_inserter (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_chan(in_chan),
    .in_data(in_data), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .out_vld(out_vld), .out_chan(out_chan),
    .out_data(out_data)
  );

  // tone restated: symmetric half-cycle, second half has sign bit set
  function automatic logic [7:0] exp_tone(int i);
    logic [7:0] b;
    b = ((i % 4) == 0 || (i % 4) == 3) ? 8'h1E : 8'h0B;
    if ((i % 8) >= 4) b = b | 8'h80;
    return b;
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check just after the posedge
  task automatic step(bit vld, int ch, logic [7:0] d, bit wr, int sel,
                      logic [7:0] wd, string req);
    logic [7:0] e_data;
    bool_hit: begin end
    e_data = d;
    if (vld && ch >= 1 && ch <= 24 && m_active[ch-1]) e_data = exp_tone(m_idx);
    in_vld = vld; in_chan = 5'(ch); in_data = d;
    reg_wr = wr; reg_sel = 2'(sel); reg_wdata = wd;
    @(posedge clk);
    if (vld && ch == 24) begin m_active = m_stage; m_idx = (m_idx + 1) % 8; end
    if (wr && sel < 3) m_stage[sel*8 +: 8] = wd;
    #1;
    if (vld)
      check(out_vld && out_chan == 5'(ch) && out_data == e_data, req,
            {3'b0, out_vld, out_chan[3:0], out_data}, {3'b0, 1'b1, 4'(ch), e_data});
    else
      check(!out_vld, req, {15'b0, out_vld}, 16'h0);
    @(negedge clk);
    in_vld = 0; reg_wr = 0;
  endtask

  task automatic frame(int seed, bit gaps, string req);
    for (int c = 1; c <= 24; c++) begin
      step(1, c, 8'(c * 37 + seed * 11 + 5), 0, 0, 8'h00, req);
      if (gaps && (c % 3 == 0)) step(0, 0, 8'h00, 0, 0, 8'h00, "R9");
    end
  endtask

  task automatic write_map(logic [23:0] m);
    for (int s = 0; s < 3; s++) step(0, 0, 8'h00, 1, s, m[s*8 +: 8], "R3");
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check(out_vld == 0 && out_chan == 0 && out_data == 0, "R1",
          {3'b0, out_vld, out_chan[3:0], out_data}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    frame(0, 0, "R1");
    // R7: mid-frame writes wait for the boundary
    for (int c = 1; c <= 12; c++) step(1, c, 8'(c), 0, 0, 8'h00, "R7");
    step(0, 0, 8'h00, 1, 0, 8'hA5, "R7");
    step(0, 0, 8'h00, 1, 2, 8'h81, "R7");
    for (int c = 13; c <= 24; c++) step(1, c, 8'(c), 0, 0, 8'h00, "R7");
    frame(1, 0, "R7");
    // R3 / R4: walk a single enable across every channel
    for (int k = 0; k < 24; k++) begin
      write_map(24'(1) << k);
      frame(k, 0, "R3");
      frame(k + 1, 0, "R4");
    end
    // R5 / R6: all enabled, more than one tone period
    write_map(24'hFFFFFF);
    for (int f = 0; f < 10; f++) frame(f, 0, "R5");
    // R3: select 3 is ignored
    write_map(24'h5A3C96);
    frame(2, 0, "R3");
    step(0, 0, 8'h00, 1, 3, 8'hFF, "R3");
    frame(3, 0, "R3");
    frame(4, 0, "R3");
    // R8: stray channel numbers pass and do not mark a boundary
    write_map(24'h00F00F);
    for (int c = 1; c <= 24; c++) begin
      step(1, c, 8'(c + 100), 0, 0, 8'h00, "R8");
      if (c == 5) begin
        step(1, 0, 8'h77, 0, 0, 8'h00, "R8");
        step(1, 25, 8'h66, 0, 0, 8'h00, "R8");
        step(1, 31, 8'h55, 0, 0, 8'h00, "R8");
      end
    end
    frame(5, 0, "R8");
    // R9: idle gaps
    frame(6, 1, "R9");
    frame(7, 1, "R9");
    // R7: write in the same cycle as the channel-24 byte
    write_map(24'hFFFFFF);
    frame(8, 0, "R7");
    for (int c = 1; c <= 23; c++) step(1, c, 8'(c), 0, 0, 8'h00, "R7");
    step(1, 24, 8'h24, 1, 0, 8'h00, "R7");
    frame(9, 0, "R7");
    frame(10, 0, "R7");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule